// File: doc/BRIEF.md
# Low-Power Mode Entry Sequencer

This block decides when the clocks of a system may stop and how they come back. Software writes a two-bit mode register. Setting the idle bit stops only the processor clock. The bus clocks and the peripheral clocks keep running, and any pending interrupt restarts the processor clock.

Setting the stop bit starts an ordered shutdown:

- The bus controller is asked to drain its outstanding transfers.
- Only after the bus controller acknowledges is the memory controller asked to put SDRAM into self-refresh.
- Once self-refresh is acknowledged, the system clocks are gated and the system clock source is moved to the PLL reference.
- In the following cycle the PLLs stop. The crystal oscillator also stops, unless a keep-oscillator configuration input asks for it to stay on.

Four wake sources end stop mode. On wake the block holds every clock off through an oscillator settle interval and then a PLL lock interval. The settle interval is skipped when the oscillator was kept running. Both intervals are loaded from reload inputs.

After the clocks return, the block asks the memory controller to leave self-refresh and waits for the acknowledge to drop. It then releases the bus request and returns to normal operation. A wake event that arrives while the shutdown is still in progress is latched, so the sequence completes and leaves sleep at once.

Per-block clock enables are combined with the system clock state without a register stage, so a change to an enable bit takes effect in the same cycle. The hardware never clears the mode bits; software clears them after wake-up.

Top module: `lp_mode_seq`

## Requirements
- R1: After synchronous reset, state_o reads 0 (normal). The processor, system and PLL enables read 1, the oscillator enable reads 1, sysclk_src_ref_o reads 0, both request outputs read 0, and mode_bits_o reads 0.
- R2: A write loads mode_bits_o from mode_wdata_i (bit 0 = idle, bit 1 = stop), and the bits never change without a write. A write with only bit 0 set moves state_o to 1 (idle) at the next clock edge. In idle, cpu_clk_en_o is 0 while sys_clk_en_o stays 1.
- R3: In idle, irq_any_i at 1 returns state_o to 0 at the next edge and turns cpu_clk_en_o back on. The idle bit stays set.
- R4: A write with bit 1 set, with or without bit 0, moves state_o to 2 (bus drain) at the next edge. In that state bus_drain_req_o is 1 and cpu_clk_en_o is 0.
- R5: sref_req_o stays 0 for as long as bus_drain_ack_i is 0 in state 2. The edge after the acknowledge moves state_o to 3 and raises sref_req_o.
- R6: The edge after sref_ack_i moves state_o to 4. In state 4 the system clocks are off, sysclk_src_ref_o is 1 and the PLL is still on. The next edge moves state_o to 5 (sleep). In sleep pll_en_o is 0 and osc_en_o equals keep_osc_i as sampled in state 4.
- R7: In sleep, any of the four wake_src_i bits leaves sleep at the next edge (bit 0 external interrupt, bit 1 RTC alarm, bit 2 RTC tick, bit 3 battery fault). Without a wake, sleep persists, including after wake pulses that came while the state was 0.
- R8: On leaving sleep, state 6 (oscillator on, PLL off) lasts settle_reload_i+1 cycles, then state 7 (PLL on) lasts lock_reload_i+1 cycles. With the oscillator kept running, state 6 is skipped. The system clock stays off throughout. It returns S+L+3 edges after the wake is applied, or L+2 edges with the oscillator kept.
- R9: A wake pulse seen in state 2, 3 or 4 is latched, and sleep is then left after a single cycle with no wake input present.
- R10: State 8 turns the clocks back on with sysclk_src_ref_o at 0 and sref_req_o at 0. bus_drain_req_o is held until sref_ack_i falls. The next edge then gives state_o 0, bus_drain_req_o 0 and cpu_clk_en_o 1.
- R11: Each bit of blk_clk_en_o equals the matching blk_gate_i bit ANDed with sys_clk_en_o, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | 2 | Write data: bit 0 idle, bit 1 stop |
| mode_bits_o | output | 2 | Current mode register contents |
| keep_osc_i | input | 1 | Keep the crystal oscillator running in sleep |
| settle_reload_i | input | CNT_W | Oscillator settle reload value |
| lock_reload_i | input | CNT_W | PLL lock reload value |
| irq_any_i | input | 1 | Any enabled interrupt pending (idle exit) |
| wake_src_i | input | 4 | Wake sources: ext, RTC alarm, RTC tick, battery fault |
| bus_drain_req_o | output | 1 | Request to bus controller to finish transfers |
| bus_drain_ack_i | input | 1 | Bus controller drain acknowledge |
| sref_req_o | output | 1 | Self-refresh request to memory controller |
| sref_ack_i | input | 1 | Self-refresh acknowledge |
| blk_gate_i | input | NUM_BLK | Per-block clock gate enables |
| cpu_clk_en_o | output | 1 | Processor clock enable |
| sys_clk_en_o | output | 1 | System clock enable |
| blk_clk_en_o | output | NUM_BLK | Per-block clock enables after system gating |
| sysclk_src_ref_o | output | 1 | 1 selects the PLL reference as system clock source |
| pll_en_o | output | 1 | PLL enable |
| osc_en_o | output | 1 | Crystal oscillator enable |
| state_o | output | 4 | Current sequencer state code |

## Verification
The bench builds the block with CNT_W = 8 and NUM_BLK = 4. The narrow counter makes the largest reload value, 255, cheap to run, so the full-scale settle and lock delays are measured edge by edge next to the zero-reload case. Four gate bits are enough to show that per-block enables follow the system clock in the same cycle. A table of settle, lock and keep-oscillator combinations drives complete stop and wake round trips. Directed tests then cover idle, the drain ordering, latched early wake, each wake source and the self-refresh exit handshake.

// File: rtl/lps_pkg.sv
package lps_pkg;

    localparam int WAKE_SRCS = 4;

    typedef enum logic [3:0] {
        ST_RUN    = 4'd0,
        ST_IDLE   = 4'd1,
        ST_DRAIN  = 4'd2,
        ST_SREF   = 4'd3,
        ST_CLKSW  = 4'd4,
        ST_SLEEP  = 4'd5,
        ST_SETTLE = 4'd6,
        ST_LOCK   = 4'd7,
        ST_SREXIT = 4'd8
    } lps_state_e;

    typedef struct packed {
        logic batt_fault;
        logic rtc_tick;
        logic rtc_alarm;
        logic ext_irq;
    } wake_vec_t;

    typedef struct packed {
        logic cpu_clk;
        logic sys_clk;
        logic src_ref;
        logic pll;
        logic osc;
        logic bus_req;
        logic sr_req;
    } lps_ctrl_t;

    function automatic logic wake_arm(lps_state_e st);
        return (st == ST_DRAIN) || (st == ST_SREF) || (st == ST_CLKSW);
    endfunction

    function automatic lps_ctrl_t decode_ctrl(lps_state_e st, logic osc_kept);
        lps_ctrl_t c;
        c = '{cpu_clk: 1'b0, sys_clk: 1'b1, src_ref: 1'b0, pll: 1'b1,
              osc: 1'b1, bus_req: 1'b1, sr_req: 1'b0};
        case (st)
            ST_RUN: begin
                c.cpu_clk = 1'b1;
                c.bus_req = 1'b0;
            end
            ST_IDLE:  c.bus_req = 1'b0;
            ST_DRAIN: ;
            ST_SREF:  c.sr_req = 1'b1;
            ST_CLKSW: begin
                c.sys_clk = 1'b0;
                c.src_ref = 1'b1;
                c.sr_req  = 1'b1;
            end
            ST_SLEEP: begin
                c.sys_clk = 1'b0;
                c.src_ref = 1'b1;
                c.sr_req  = 1'b1;
                c.pll     = 1'b0;
                c.osc     = osc_kept;
            end
            ST_SETTLE: begin
                c.sys_clk = 1'b0;
                c.src_ref = 1'b1;
                c.sr_req  = 1'b1;
                c.pll     = 1'b0;
            end
            ST_LOCK: begin
                c.sys_clk = 1'b0;
                c.src_ref = 1'b1;
                c.sr_req  = 1'b1;
            end
            ST_SREXIT: ;
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/lps_mode_reg.sv
module lps_mode_reg (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_idle,
    input  logic wr_stop,
    output logic idle_q,
    output logic stop_q,
    output logic idle_go,
    output logic stop_go
);

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_q <= 1'b0;
            stop_q <= 1'b0;
        end else if (wr_en) begin
            idle_q <= wr_idle;
            stop_q <= wr_stop;
        end
    end

    // a mode takes effect on the write that sets its bit
    assign idle_go = wr_en & wr_idle;
    assign stop_go = wr_en & wr_stop;

    // R2: hardware never alters the mode bits on its own
    p_mode_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(idle_q) && $stable(stop_q)));

endmodule

// File: rtl/lps_wake_latch.sv
module lps_wake_latch
    import lps_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      arm,
    input  logic      clear,
    input  wake_vec_t src,
    output logic      pend,
    output logic      wake_now
);

    logic any_src;

    assign any_src = src.ext_irq | src.rtc_alarm | src.rtc_tick | src.batt_fault;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
        end else if (clear) begin
            pend <= 1'b0;
        end else if (arm && any_src) begin
            pend <= 1'b1;
        end
    end

    assign wake_now = any_src | pend;

    // R9: a latched early wake is kept until sleep consumes it
    p_pend_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (pend && !clear) |=> pend);

endmodule

// File: rtl/lps_delay_timer.sv
module lps_delay_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

    // R8: an expired timer stays expired until reloaded
    p_no_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        (zero && !load) |=> zero);

endmodule

// File: rtl/lps_seq_fsm.sv
module lps_seq_fsm
    import lps_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       idle_go,
    input  logic       stop_go,
    input  logic       irq_any,
    input  logic       bus_ack,
    input  logic       sr_ack,
    input  logic       wake_now,
    input  logic       keep_osc,
    input  logic       settle_zero,
    input  logic       lock_zero,
    output lps_state_e st_q,
    output logic       osc_kept_q,
    output logic       settle_load,
    output logic       settle_run,
    output logic       lock_load,
    output logic       lock_run,
    output logic       wake_clear
);

    lps_state_e st_d;

    always_comb begin
        st_d        = st_q;
        settle_load = 1'b0;
        settle_run  = 1'b0;
        lock_load   = 1'b0;
        lock_run    = 1'b0;
        wake_clear  = 1'b0;
        case (st_q)
            ST_RUN: begin
                if (stop_go)      st_d = ST_DRAIN;
                else if (idle_go) st_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (irq_any)      st_d = ST_RUN;
                else if (stop_go) st_d = ST_DRAIN;
            end
            ST_DRAIN: if (bus_ack) st_d = ST_SREF;
            ST_SREF:  if (sr_ack)  st_d = ST_CLKSW;
            ST_CLKSW: st_d = ST_SLEEP;
            ST_SLEEP: begin
                if (wake_now) begin
                    wake_clear = 1'b1;
                    if (osc_kept_q) begin
                        st_d      = ST_LOCK;
                        lock_load = 1'b1;
                    end else begin
                        st_d        = ST_SETTLE;
                        settle_load = 1'b1;
                    end
                end
            end
            ST_SETTLE: begin
                settle_run = 1'b1;
                if (settle_zero) begin
                    st_d      = ST_LOCK;
                    lock_load = 1'b1;
                end
            end
            ST_LOCK: begin
                lock_run = 1'b1;
                if (lock_zero) st_d = ST_SREXIT;
            end
            ST_SREXIT: if (!sr_ack) st_d = ST_RUN;
            default: st_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_RUN;
            osc_kept_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_CLKSW) osc_kept_q <= keep_osc;
        end
    end

    // R5: drain state holds until the bus controller acknowledges
    p_drain_wait_r5: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DRAIN && !bus_ack) |=> (st_q == ST_DRAIN));

    // R9: any pending wake ends sleep at the next edge
    p_sleep_exit_r9: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SLEEP && wake_now) |=> (st_q != ST_SLEEP));

    // R10: normal mode is reached only once self-refresh has been released
    p_srexit_wait_r10: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SREXIT && sr_ack) |=> (st_q == ST_SREXIT));

endmodule

// File: rtl/lp_mode_seq.sv
module lp_mode_seq
    import lps_pkg::*;
#(
    parameter int NUM_BLK = 8,
    parameter int CNT_W   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mode_wr_i,
    input  logic [1:0]         mode_wdata_i,
    output logic [1:0]         mode_bits_o,
    input  logic               keep_osc_i,
    input  logic [CNT_W-1:0]   settle_reload_i,
    input  logic [CNT_W-1:0]   lock_reload_i,
    input  logic               irq_any_i,
    input  logic [3:0]         wake_src_i,
    output logic               bus_drain_req_o,
    input  logic               bus_drain_ack_i,
    output logic               sref_req_o,
    input  logic               sref_ack_i,
    input  logic [NUM_BLK-1:0] blk_gate_i,
    output logic               cpu_clk_en_o,
    output logic               sys_clk_en_o,
    output logic [NUM_BLK-1:0] blk_clk_en_o,
    output logic               sysclk_src_ref_o,
    output logic               pll_en_o,
    output logic               osc_en_o,
    output logic [3:0]         state_o
);

    localparam int NUM_TMR = 2;
    localparam int TMR_SETTLE = 0;
    localparam int TMR_LOCK   = 1;

    logic       idle_q, stop_q, idle_go, stop_go;
    logic       wake_pend, wake_now, wake_clear;
    lps_state_e st;
    logic       osc_kept;
    lps_ctrl_t  ctrl;

    logic [CNT_W-1:0] tmr_reload [NUM_TMR];
    logic [NUM_TMR-1:0] tmr_load, tmr_run, tmr_zero;

    lps_mode_reg u_mode (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (mode_wr_i),
        .wr_idle (mode_wdata_i[0]),
        .wr_stop (mode_wdata_i[1]),
        .idle_q  (idle_q),
        .stop_q  (stop_q),
        .idle_go (idle_go),
        .stop_go (stop_go)
    );

    lps_wake_latch u_wake (
        .clk      (clk),
        .rst      (rst),
        .arm      (wake_arm(st)),
        .clear    (wake_clear),
        .src      (wake_vec_t'(wake_src_i)),
        .pend     (wake_pend),
        .wake_now (wake_now)
    );

    lps_seq_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .idle_go     (idle_go),
        .stop_go     (stop_go),
        .irq_any     (irq_any_i),
        .bus_ack     (bus_drain_ack_i),
        .sr_ack      (sref_ack_i),
        .wake_now    (wake_now),
        .keep_osc    (keep_osc_i),
        .settle_zero (tmr_zero[TMR_SETTLE]),
        .lock_zero   (tmr_zero[TMR_LOCK]),
        .st_q        (st),
        .osc_kept_q  (osc_kept),
        .settle_load (tmr_load[TMR_SETTLE]),
        .settle_run  (tmr_run[TMR_SETTLE]),
        .lock_load   (tmr_load[TMR_LOCK]),
        .lock_run    (tmr_run[TMR_LOCK]),
        .wake_clear  (wake_clear)
    );

    assign tmr_reload[TMR_SETTLE] = settle_reload_i;
    assign tmr_reload[TMR_LOCK]   = lock_reload_i;

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        lps_delay_timer #(.CNT_W(CNT_W)) u_tmr (
            .clk      (clk),
            .rst      (rst),
            .load     (tmr_load[t]),
            .load_val (tmr_reload[t]),
            .run      (tmr_run[t]),
            .zero     (tmr_zero[t])
        );
    end

    assign ctrl = decode_ctrl(st, osc_kept);

    assign mode_bits_o      = {stop_q, idle_q};
    assign cpu_clk_en_o     = ctrl.cpu_clk;
    assign sys_clk_en_o     = ctrl.sys_clk;
    assign sysclk_src_ref_o = ctrl.src_ref;
    assign pll_en_o         = ctrl.pll;
    assign osc_en_o         = ctrl.osc;
    assign bus_drain_req_o  = ctrl.bus_req;
    assign sref_req_o       = ctrl.sr_req;
    assign state_o          = st;

    for (genvar b = 0; b < NUM_BLK; b++) begin : g_gate
        assign blk_clk_en_o[b] = blk_gate_i[b] & ctrl.sys_clk;
    end

    // R5: self-refresh is only requested after the drain was acknowledged
    p_sref_order_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(sref_req_o) |-> $past(bus_drain_ack_i));

    // R8: system clocks resume only from a running PLL on its own source
    p_clk_after_pll_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_clk_en_o) |-> ($past(pll_en_o) && !sysclk_src_ref_o));

    // R10: the bus request is dropped only together with a return to normal
    p_bus_release_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_drain_req_o) |-> (cpu_clk_en_o && $past(!sref_ack_i)));

    // R6: the PLL stops only after the clock source has been switched
    p_pll_off_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(pll_en_o) |-> ($past(sysclk_src_ref_o) && !sys_clk_en_o));

endmodule

// File: tb/lp_mode_seq_tb.sv
module lp_mode_seq_tb;

    localparam int NB = 4;
    localparam int CW = 8;
    localparam int NVEC = 6;
    // {settle, lock, keep, expected edges from wake to clocks on}
    localparam logic [32:0] VEC [NVEC] = '{
        {8'd0,   8'd0,   1'b0, 16'd3},
        {8'd3,   8'd2,   1'b0, 16'd8},
        {8'd5,   8'd4,   1'b1, 16'd6},
        {8'd0,   8'd7,   1'b1, 16'd9},
        {8'd255, 8'd255, 1'b0, 16'd513},
        {8'd10,  8'd0,   1'b0, 16'd13}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode_wr = 1'b0;
    logic [1:0]    mode_wdata = 2'b00;
    logic [1:0]    mode_bits;
    logic          keep_osc = 1'b0;
    logic [CW-1:0] settle_rl = '0;
    logic [CW-1:0] lock_rl = '0;
    logic          irq_any = 1'b0;
    logic [3:0]    wake_src = 4'b0;
    logic          bus_req, bus_ack = 1'b0;
    logic          sr_req, sr_ack = 1'b0;
    logic [NB-1:0] gate = '0;
    logic          cpu_en, sys_en, src_ref, pll_en, osc_en;
    logic [NB-1:0] blk_en;
    logic [3:0]    state;

    int n_chk = 0;
    int n_fail = 0;

    lp_mode_seq #(.NUM_BLK(NB), .CNT_W(CW)) u_dut (
        .clk (clk), .rst (rst),
        .mode_wr_i (mode_wr), .mode_wdata_i (mode_wdata), .mode_bits_o (mode_bits),
        .keep_osc_i (keep_osc), .settle_reload_i (settle_rl), .lock_reload_i (lock_rl),
        .irq_any_i (irq_any), .wake_src_i (wake_src),
        .bus_drain_req_o (bus_req), .bus_drain_ack_i (bus_ack),
        .sref_req_o (sr_req), .sref_ack_i (sr_ack),
        .blk_gate_i (gate), .cpu_clk_en_o (cpu_en), .sys_clk_en_o (sys_en),
        .blk_clk_en_o (blk_en), .sysclk_src_ref_o (src_ref),
        .pll_en_o (pll_en), .osc_en_o (osc_en), .state_o (state)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic write_mode(input logic [1:0] d);
        mode_wr = 1'b1;
        mode_wdata = d;
        step();
        mode_wr = 1'b0;
    endtask

    // drive a stop request up to the sleep state
    task automatic enter_sleep();
        write_mode(2'b10);
        bus_ack = 1'b1;
        step();
        sr_ack = 1'b1;
        step();
        step();
    endtask

    // finish self-refresh exit and clear the mode register
    task automatic leave_srexit();
        sr_ack = 1'b0;
        step();
        bus_ack = 1'b0;
        write_mode(2'b00);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int cnt;
        repeat (3) step();
        rst = 1'b0;
        step();

        // R1 reset state
        chk("R1 state", state, 0);
        chk("R1 clocks", {cpu_en, sys_en, pll_en, osc_en}, 4'b1111);
        chk("R1 src/req", {src_ref, bus_req, sr_req}, 3'b000);
        chk("R1 mode", mode_bits, 0);

        // table of stop/wake round trips
        for (int i = 0; i < NVEC; i++) begin
            settle_rl = VEC[i][32:25];
            lock_rl   = VEC[i][24:17];
            keep_osc  = VEC[i][16];
            enter_sleep();
            chk("R6 sleep state", state, 5);
            chk("R6 sleep pll/osc", {pll_en, osc_en}, {1'b0, keep_osc});
            wake_src = 4'b0001 << (i % 4);
            cnt = 0;
            do begin
                step();
                wake_src = 4'b0;
                cnt++;
            end while (!sys_en && cnt < 2000);
            chk("R8 wake to clock edges", cnt, int'(VEC[i][15:0]));
            chk("R10 srexit state", state, 8);
            chk("R10 srexit outputs", {src_ref, sr_req, bus_req}, 3'b001);
            leave_srexit();
            chk("R10 back to normal", {state, bus_req, cpu_en}, {4'd0, 1'b0, 1'b1});
        end

        // R2/R3 idle mode
        write_mode(2'b01);
        chk("R2 idle state", state, 1);
        chk("R2 idle clocks", {cpu_en, sys_en}, 2'b01);
        step();
        step();
        chk("R2 idle persists", state, 1);
        irq_any = 1'b1;
        step();
        irq_any = 1'b0;
        chk("R3 idle exit", {state, cpu_en}, {4'd0, 1'b1});
        chk("R3 idle bit kept", mode_bits, 2'b01);
        write_mode(2'b00);

        // R4/R5 stop with both bits, drain waits for ack
        keep_osc = 1'b0;
        settle_rl = 8'd2;
        lock_rl = 8'd1;
        write_mode(2'b11);
        chk("R4 drain state", {state, bus_req, cpu_en}, {4'd2, 1'b1, 1'b0});
        repeat (4) step();
        chk("R5 no sref before ack", {state, sr_req}, {4'd2, 1'b0});
        // R9 wake during drain gets latched
        wake_src = 4'b1000;
        step();
        wake_src = 4'b0;
        bus_ack = 1'b1;
        step();
        chk("R5 sref state", {state, sr_req}, {4'd3, 1'b1});
        sr_ack = 1'b1;
        step();
        chk("R6 clksw", {state, sys_en, src_ref, pll_en}, {4'd4, 1'b0, 1'b1, 1'b1});
        gate = 4'b1011;
        #1;
        chk("R11 gated off", blk_en, 0);
        step();
        chk("R9 sleep reached", state, 5);
        step();
        chk("R9 latched wake leaves sleep", state, 6);
        repeat (7) step();
        chk("R8 clocks back", {state, sys_en}, {4'd8, 1'b1});
        #1;
        chk("R11 gated follows", blk_en, 4'b1011);
        gate = 4'b0110;
        #1;
        chk("R11 same cycle", blk_en, 4'b0110);
        step();
        chk("R10 held while ack high", {state, bus_req}, {4'd8, 1'b1});
        leave_srexit();
        chk("R2 mode cleared by write", mode_bits, 0);

        // R7 wake in normal mode is not remembered; sleep persists
        wake_src = 4'b0100;
        step();
        wake_src = 4'b0;
        enter_sleep();
        repeat (5) step();
        chk("R7 no wake stays asleep", state, 5);
        wake_src = 4'b0010;
        step();
        wake_src = 4'b0;
        chk("R7 rtc alarm wakes", state, 6);
        cnt = 0;
        while (!sys_en && cnt < 100) begin
            step();
            cnt++;
        end
        leave_srexit();
        chk("R7 returned to normal", state, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule